// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Unit

This unit sits beside the datapath of a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback). It watches the register numbers carried by the instructions in flight and decides, each cycle, where the two execute-stage operands come from, whether the front of the pipeline must freeze for a load-use dependence, and whether fetch must wait on an unresolved branch.

Operands are read in decode and every result is written in writeback. The register file writes in the first half of a cycle and reads in the second half. This means only read-after-write dependences matter, and a writeback-to-decode pair needs no bypass. A result still in the execute/memory or memory/writeback register is forwarded into execute. A load feeding the very next instruction costs one stall cycle: the PC and the fetch/decode register hold, and a bubble with all control bits cleared enters the decode/execute register. After that cycle the loaded value is forwarded from memory/writeback. A branch holds fetch from the cycle it sits in decode until the cycle its outcome is reported as resolved at the end of execute.

Top module: `hazard_ctrl`

## Requirements
- R1: `fwd_a` (for `ex_rs1`) and `fwd_b` (for `ex_rs2`) are 2'b01 when the memory-stage instruction writes (`mem_we`), is not a load (`mem_load` low), and `mem_rd` equals the nonzero source. The code 2'b11 never appears.
- R2: Without an R1 match, the select is 2'b10 when `wb_we` is high and `wb_rd` equals the nonzero source. With neither match, it is 2'b00 (register-file value).
- R3: When both the memory and writeback stages target the same source, the memory-stage (younger) result wins with 2'b01.
- R4: Register 0 is never forwarded and never causes a stall, whatever the stage flags say.
- R5: A load in the memory stage is never a forwarding source. Its source falls through to the writeback match or to 2'b00.
- R6: When the execute-stage instruction is a register-writing load whose nonzero `ex_rd` equals `id_rs1` or `id_rs2`, `pc_hold` and `idex_bubble` are both high in that same cycle. Otherwise both are low.
- R7: A non-load producer in execute that matches a decode source causes no stall.
- R8: `fetch_hold` is high in every cycle in which `dec_branch` is high.
- R9: Once a branch leaves decode (`dec_branch` high and no stall at a clock edge), `fetch_hold` stays high in the following cycles until the cycle in which `br_resolved` is high. In that cycle, `fetch_hold` is low unless a new branch is in decode. A branch frozen in decode by a stall does not start this wait early.
- R10: After reset, with all inputs low, all outputs are zero and any branch wait begun before reset is forgotten.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id_rs1 | input | REG_AW | First source register of the decode instruction |
| id_rs2 | input | REG_AW | Second source register of the decode instruction |
| ex_rs1 | input | REG_AW | First source register of the execute instruction |
| ex_rs2 | input | REG_AW | Second source register of the execute instruction |
| ex_rd | input | REG_AW | Destination of the execute instruction |
| ex_we | input | 1 | Execute instruction writes a register |
| ex_load | input | 1 | Execute instruction is a load |
| mem_rd | input | REG_AW | Destination of the memory-stage instruction |
| mem_we | input | 1 | Memory-stage instruction writes a register |
| mem_load | input | 1 | Memory-stage instruction is a load |
| wb_rd | input | REG_AW | Destination of the writeback instruction |
| wb_we | input | 1 | Writeback instruction writes a register |
| dec_branch | input | 1 | A branch is in decode |
| br_resolved | input | 1 | The branch in execute resolves this cycle |
| fwd_a | output | 2 | Operand A source: 00 file, 01 exec/mem, 10 mem/wb |
| fwd_b | output | 2 | Operand B source, same encoding |
| pc_hold | output | 1 | Hold PC and fetch/decode register |
| idex_bubble | output | 1 | Load a cleared bubble into decode/execute |
| fetch_hold | output | 1 | Suspend fetch for a pending branch |

## Verification
The assertions assume that the stage flags describe a real instruction stream. A branch resolves only while one is waiting, and no second branch reaches decode before the first resolves. The stimulus keeps to this by replaying short instruction sequences, such as a load, its stalled consumer and the forward that follows, or a branch and its resolution. Some cycles deliberately set flags on register 0 or on loads in the memory stage to probe the exclusions. These cycles never break the branch ordering.

// File: rtl/hazard_ctrl.sv
module hazard_ctrl #(
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] id_rs1,
  input  logic [REG_AW-1:0] id_rs2,
  input  logic [REG_AW-1:0] ex_rs1,
  input  logic [REG_AW-1:0] ex_rs2,
  input  logic [REG_AW-1:0] ex_rd,
  input  logic              ex_we,
  input  logic              ex_load,
  input  logic [REG_AW-1:0] mem_rd,
  input  logic              mem_we,
  input  logic              mem_load,
  input  logic [REG_AW-1:0] wb_rd,
  input  logic              wb_we,
  input  logic              dec_branch,
  input  logic              br_resolved,
  output logic [1:0]        fwd_a,
  output logic [1:0]        fwd_b,
  output logic              pc_hold,
  output logic              idex_bubble,
  output logic              fetch_hold
);
  localparam int          NUM_OPS = 2;
  localparam logic [1:0]  SEL_RF  = 2'b00;
  localparam logic [1:0]  SEL_MEM = 2'b01;
  localparam logic [1:0]  SEL_WB  = 2'b10;

  logic [NUM_OPS-1:0][REG_AW-1:0] ex_src;
  logic [NUM_OPS-1:0][1:0]        sel;

  assign ex_src = {ex_rs2, ex_rs1};

  for (genvar i = 0; i < NUM_OPS; i++) begin : g_op
    logic nz, hit_mem, hit_wb;
    assign nz      = |ex_src[i];
    assign hit_mem = nz && mem_we && !mem_load && (mem_rd == ex_src[i]);
    assign hit_wb  = nz && wb_we && (wb_rd == ex_src[i]);
    assign sel[i]  = hit_mem ? SEL_MEM : (hit_wb ? SEL_WB : SEL_RF);
  end

  assign fwd_a = sel[0];
  assign fwd_b = sel[1];

  logic ld_dst, ld_use;
  assign ld_dst = ex_load && ex_we && (|ex_rd);
  assign ld_use = ld_dst && ((ex_rd == id_rs1) || (ex_rd == id_rs2));

  assign pc_hold     = ld_use;
  assign idex_bubble = ld_use;

  logic br_pend;
  always_ff @(posedge clk) begin
    if (!rst_n)                      br_pend <= 1'b0;
    else if (dec_branch && !ld_use)  br_pend <= 1'b1;
    else if (br_resolved)            br_pend <= 1'b0;
  end

  assign fetch_hold = dec_branch || (br_pend && !br_resolved);
endmodule

// File: rtl/hazard_ctrl_chk.sv
module hazard_ctrl_chk #(
  parameter int REG_AW = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [REG_AW-1:0] ex_rs1,
  input logic [REG_AW-1:0] ex_rs2,
  input logic              ex_load,
  input logic [REG_AW-1:0] mem_rd,
  input logic              mem_we,
  input logic              mem_load,
  input logic              dec_branch,
  input logic              br_resolved,
  input logic [1:0]        fwd_a,
  input logic [1:0]        fwd_b,
  input logic              pc_hold,
  input logic              idex_bubble,
  input logic              fetch_hold
);
  logic issued;
  always_ff @(posedge clk) begin
    if (!rst_n) issued <= 1'b0;
    else        issued <= dec_branch && !pc_hold;
  end

  AST_SEL_LEGAL:    assert property (@(posedge clk) disable iff (!rst_n) (fwd_a != 2'b11) && (fwd_b != 2'b11)); // R1
  AST_ZERO_SRC_A:   assert property (@(posedge clk) disable iff (!rst_n) (ex_rs1 == '0) |-> (fwd_a == 2'b00)); // R4
  AST_ZERO_SRC_B:   assert property (@(posedge clk) disable iff (!rst_n) (ex_rs2 == '0) |-> (fwd_b == 2'b00)); // R4
  AST_YOUNGER_WINS: assert property (@(posedge clk) disable iff (!rst_n) (fwd_a == 2'b10) |-> !(mem_we && !mem_load && mem_rd == ex_rs1)); // R3
  AST_NO_LOAD_FWD:  assert property (@(posedge clk) disable iff (!rst_n) mem_load |-> (fwd_a != 2'b01) && (fwd_b != 2'b01)); // R5
  AST_STALL_PAIR:   assert property (@(posedge clk) disable iff (!rst_n) pc_hold == idex_bubble); // R6
  AST_NONLOAD_GO:   assert property (@(posedge clk) disable iff (!rst_n) !ex_load |-> !pc_hold); // R7
  AST_BR_DEC_HOLD:  assert property (@(posedge clk) disable iff (!rst_n) dec_branch |-> fetch_hold); // R8
  AST_BR_WAIT:      assert property (@(posedge clk) disable iff (!rst_n) (issued && !br_resolved) |-> fetch_hold); // R9
  AST_BR_RELEASE:   assert property (@(posedge clk) disable iff (!rst_n) (br_resolved && !dec_branch) |-> !fetch_hold); // R9
endmodule

bind hazard_ctrl hazard_ctrl_chk #(.REG_AW(REG_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ex_rs1(ex_rs1), .ex_rs2(ex_rs2), .ex_load(ex_load),
  .mem_rd(mem_rd), .mem_we(mem_we), .mem_load(mem_load), .dec_branch(dec_branch),
  .br_resolved(br_resolved), .fwd_a(fwd_a), .fwd_b(fwd_b), .pc_hold(pc_hold),
  .idex_bubble(idex_bubble), .fetch_hold(fetch_hold)
);

// File: tb/hazard_ctrl_tb.sv
`timescale 1ns/1ps
module hazard_ctrl_tb;
  localparam int AW = 5;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n;
  logic [AW-1:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd;
  logic ex_we, ex_load, mem_we, mem_load, wb_we, dec_branch, br_resolved;
  logic [1:0] fwd_a, fwd_b;
  logic pc_hold, idex_bubble, fetch_hold;

  hazard_ctrl #(.REG_AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .id_rs1(id_rs1), .id_rs2(id_rs2),
    .ex_rs1(ex_rs1), .ex_rs2(ex_rs2), .ex_rd(ex_rd), .ex_we(ex_we), .ex_load(ex_load),
    .mem_rd(mem_rd), .mem_we(mem_we), .mem_load(mem_load), .wb_rd(wb_rd), .wb_we(wb_we),
    .dec_branch(dec_branch), .br_resolved(br_resolved), .fwd_a(fwd_a), .fwd_b(fwd_b),
    .pc_hold(pc_hold), .idex_bubble(idex_bubble), .fetch_hold(fetch_hold)
  );

  typedef struct {
    logic [1:0] fa, fb;
    logic       stall, fh;
    string      req;
  } exp_t;

  exp_t q[$];
  int checks = 0, errors = 0;
  logic pend = 1'b0;
  bit done = 0;

  function automatic logic [1:0] ref_fwd(input logic [AW-1:0] s);
    if (s != 0 && mem_we && !mem_load && mem_rd == s) return 2'b01;
    if (s != 0 && wb_we && wb_rd == s)                return 2'b10;
    return 2'b00;
  endfunction

  task automatic clear_in();
    {id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd} = '0;
    {ex_we, ex_load, mem_we, mem_load, wb_we, dec_branch, br_resolved} = '0;
  endtask

  // inputs must already be set; drive at posedge+1, expect at next negedge
  task automatic push(input string req);
    exp_t e;
    e.fa    = ref_fwd(ex_rs1);
    e.fb    = ref_fwd(ex_rs2);
    e.stall = ex_load && ex_we && ex_rd != 0 && (ex_rd == id_rs1 || ex_rd == id_rs2);
    e.fh    = dec_branch || (pend && !br_resolved);
    e.req   = req;
    q.push_back(e);
    if (dec_branch && !e.stall) pend = 1'b1;
    else if (br_resolved)       pend = 1'b0;
  endtask

  task automatic edge1();
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    edge1(); rst_n = 1'b0; clear_in(); pend = 1'b0;
    edge1(); edge1(); rst_n = 1'b1;
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        e = q.pop_front();
        checks++;
        if (fwd_a !== e.fa || fwd_b !== e.fb || pc_hold !== e.stall ||
            idex_bubble !== e.stall || fetch_hold !== e.fh) begin
          errors++;
          $display("FAIL %s: got fa=%b fb=%b hold=%b bub=%b fh=%b, exp fa=%b fb=%b stall=%b fh=%b",
                   e.req, fwd_a, fwd_b, pc_hold, idex_bubble, fetch_hold, e.fa, e.fb, e.stall, e.fh);
        end
      end
    end
  end

  initial begin : watchdog
    #20000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout, exp completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    rst_n = 1'b0; clear_in();
    do_reset();
    // R10 idle after reset
    push("R10");
    // R1 forward from exec/mem
    edge1(); clear_in(); ex_rs1 = 3; mem_rd = 3; mem_we = 1; push("R1");
    // R1 write flag low: no forward
    edge1(); clear_in(); ex_rs1 = 3; mem_rd = 3; mem_we = 0; push("R1");
    // R2 forward from mem/wb on operand B
    edge1(); clear_in(); ex_rs2 = 7; wb_rd = 7; wb_we = 1; push("R2");
    // R3 both stages target r5
    edge1(); clear_in(); ex_rs1 = 5; ex_rs2 = 5; mem_rd = 5; mem_we = 1; wb_rd = 5; wb_we = 1; push("R3");
    // R3 distinct operands from distinct stages
    edge1(); clear_in(); ex_rs1 = 9; ex_rs2 = 10; mem_rd = 10; mem_we = 1; wb_rd = 9; wb_we = 1; push("R3");
    // R4 register 0 everywhere
    edge1(); clear_in(); mem_we = 1; wb_we = 1; ex_we = 1; ex_load = 1; push("R4");
    // R5 load in memory stage, writeback also matches
    edge1(); clear_in(); ex_rs1 = 4; mem_rd = 4; mem_we = 1; mem_load = 1; wb_rd = 4; wb_we = 1; push("R5");
    // R5 load in memory stage alone
    edge1(); clear_in(); ex_rs2 = 4; mem_rd = 4; mem_we = 1; mem_load = 1; push("R5");
    // R6 load-use sequence: stall, bubble cycle, then forward from mem/wb
    edge1(); clear_in(); ex_rd = 6; ex_we = 1; ex_load = 1; id_rs2 = 6; push("R6");
    edge1(); clear_in(); mem_rd = 6; mem_we = 1; mem_load = 1; id_rs2 = 6; push("R6");
    edge1(); clear_in(); ex_rs2 = 6; wb_rd = 6; wb_we = 1; push("R6");
    // R6 match on first decode source
    edge1(); clear_in(); ex_rd = 12; ex_we = 1; ex_load = 1; id_rs1 = 12; push("R6");
    // R6 load without match
    edge1(); clear_in(); ex_rd = 12; ex_we = 1; ex_load = 1; id_rs1 = 13; id_rs2 = 11; push("R6");
    // R7 ALU producer matching decode
    edge1(); clear_in(); ex_rd = 8; ex_we = 1; id_rs1 = 8; push("R7");
    // R8 / R9 branch wait and release
    edge1(); clear_in(); dec_branch = 1; push("R8");
    edge1(); clear_in(); push("R9");
    edge1(); clear_in(); push("R9");
    edge1(); clear_in(); br_resolved = 1; push("R9");
    edge1(); clear_in(); push("R9");
    // R9 branch frozen in decode by a load-use stall
    edge1(); clear_in(); dec_branch = 1; ex_rd = 2; ex_we = 1; ex_load = 1; id_rs1 = 2; push("R9");
    edge1(); clear_in(); dec_branch = 1; br_resolved = 0; push("R8");
    edge1(); clear_in(); push("R9");
    edge1(); clear_in(); br_resolved = 1; push("R9");
    edge1(); clear_in(); push("R9");
    // R10 reset forgets a pending branch
    edge1(); clear_in(); dec_branch = 1; push("R8");
    do_reset();
    push("R10");
    edge1(); clear_in();
    repeat (3) @(posedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule